// File: doc/BRIEF.md
# Inter-Processor and Interval-Timer Interrupt Unit

This block holds two pending-interrupt vectors for a small group of processors (up to four). One vector carries inter-processor interrupts (IPIs) and the other carries interval-timer interrupts. Each bit of each vector drives one level-sensitive interrupt line to one processor. Software reaches the block through a single-cycle register port. Each request carries the number of the processor that issued it as a 2-bit sideband.

Four registers are decoded. The combined control register carries three packed CPU-select fields: IPI post, IPI clear and timer clear. It also carries a lone acknowledge bit that is accepted and otherwise ignored. A read of the combined register returns both vectors and the caller's own number. Two status registers return one vector each, and a write to either clears the selected bits. A queue register posts IPIs. An external tick input sets the timer bit of every processor at once. Unsupported or empty writes raise an error strobe in the same cycle and change no state.

Top module: `ipi_timer_irq_unit`

## Requirements
- R1: After reset, both pending vectors are zero. Every IPI and timer output is low.
- R2: A write to the combined register (address 0) sets the pending IPI bit of each processor selected in bits 15:12. The new value appears on the output after the next clock edge.
- R3: Bits 11:8 of a combined-register write clear the selected pending IPIs. When one write both posts and clears the same processor, the clear wins.
- R4: Bits 7:4 of a combined-register write clear the selected pending timer interrupts.
- R5: A combined-register write with only bit 28 set raises no error and leaves both vectors unchanged.
- R6: A combined-register write with bits 15:12, 11:8, 7:4 and bit 28 all zero raises the error strobe and leaves both vectors unchanged.
- R7: Posting an IPI that is already pending, or clearing one that is not pending, leaves that processor's bit unchanged.
- R8: A tick sets every processor's timer bit. If a clear of the timer bit falls in the same cycle as a tick, the tick wins.
- R9: A read of the IPI status register (address 1) returns the pending IPI vector in bits 3:0. A write to it clears the selected bits.
- R10: A read of the timer status register (address 2) returns the pending timer vector in bits 3:0. A write to it clears the selected bits.
- R11: A write to the queue register (address 3) posts IPIs to the processors selected in bits 3:0.
- R12: A write of an all-zero select vector to address 1, 2 or 3 raises the error strobe and changes neither vector.
- R13: A read of the combined register returns the pending IPI vector in bits 11:8, the pending timer vector in bits 7:4 and the requester's number in bits 1:0. All other bits read zero, and a read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 2 | Number of the requesting processor |
| rsp_rdata | output | 32 | Read data, valid in the request cycle |
| rsp_err | output | 1 | Unsupported or empty write in this cycle |
| tick | input | 1 | Interval-timer tick |
| ipi_irq | output | NCPU | Per-processor IPI level |
| tmr_irq | output | NCPU | Per-processor timer level |

## Verification
A timer tick and a software timer clear can land on the same processor in the same cycle. The bench provokes this by raising the tick input during a combined-register write whose bits 7:4 select every processor. It judges the result on the timer outputs one edge later: all of them must be set. The other collision lies inside the IPI vector, where one combined-register write posts and clears the same processor. The bench sweeps every prior state against every post and clear pattern and expects the clear to win.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int MAX_CPU = 4;
  localparam int CPU_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    RG_MISC      = 2'd0,
    RG_IPI_STAT  = 2'd1,
    RG_TMR_STAT  = 2'd2,
    RG_IPI_QUEUE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [MAX_CPU-1:0] ipi_post;
    logic [MAX_CPU-1:0] ipi_drop;
    logic [MAX_CPU-1:0] tmr_drop;
    logic               nxm_ack;
  } misc_fields_t;

  function automatic misc_fields_t misc_unpack(input logic [DATA_W-1:0] d);
    misc_fields_t f;
    f.ipi_post = d[15:12];
    f.ipi_drop = d[11:8];
    f.tmr_drop = d[7:4];
    f.nxm_ack  = d[28];
    return f;
  endfunction

  function automatic logic [DATA_W-1:0] misc_pack(input logic [MAX_CPU-1:0] ipi,
                                                  input logic [MAX_CPU-1:0] tmr,
                                                  input logic [CPU_W-1:0]   who);
    logic [DATA_W-1:0] r;
    r        = '0;
    r[11:8]  = ipi;
    r[7:4]   = tmr;
    r[1:0]   = who;
    return r;
  endfunction

  // One pending bit: set_wins picks which side a same-cycle collision favours.
  function automatic logic pend_next(input logic q, input logic s, input logic c,
                                     input logic set_wins);
    return set_wins ? ((q & ~c) | s) : ((q | s) & ~c);
  endfunction
endpackage

// File: rtl/ipt_bus_decode.sv
module ipt_bus_decode
  import ipt_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic [NCPU-1:0]         ipi_set,
  output logic [NCPU-1:0]         ipi_clr,
  output logic [NCPU-1:0]         tmr_clr,
  output logic                    wr_err,
  output logic                    rd_en
);
  misc_fields_t    mf;
  logic [NCPU-1:0] vec;
  logic [NCPU-1:0] post_m, drop_m, tdrop_m;
  logic            wr_en, misc_ok;

  assign mf      = misc_unpack(req_wdata);
  assign vec     = req_wdata[NCPU-1:0];
  assign post_m  = mf.ipi_post[NCPU-1:0];
  assign drop_m  = mf.ipi_drop[NCPU-1:0];
  assign tdrop_m = mf.tmr_drop[NCPU-1:0];
  assign wr_en   = req_valid & req_write;
  assign rd_en   = req_valid & ~req_write;
  assign misc_ok = (|post_m) | (|drop_m) | (|tdrop_m) | mf.nxm_ack;

  always_comb begin
    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    wr_err  = 1'b0;
    if (wr_en) begin
      unique case (reg_sel_e'(req_addr))
        RG_MISC: begin
          wr_err = ~misc_ok;
          if (misc_ok) begin
            ipi_set = post_m;
            ipi_clr = drop_m;
            tmr_clr = tdrop_m;
          end
        end
        RG_IPI_STAT: begin
          wr_err  = ~|vec;
          ipi_clr = vec;
        end
        RG_TMR_STAT: begin
          wr_err  = ~|vec;
          tmr_clr = vec;
        end
        RG_IPI_QUEUE: begin
          wr_err  = ~|vec;
          ipi_set = vec;
        end
        default: wr_err = 1'b1;
      endcase
    end
  end

  // R5: a lone acknowledge bit is always accepted
  p_nxm_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_addr == RG_MISC && req_wdata == (32'd1 << 28)) |-> !wr_err);
  // R12: a flagged write produces no set or clear strobes
  p_err_no_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (ipi_set == '0 && ipi_clr == '0 && tmr_clr == '0));
  // R13: reads never produce strobes
  p_read_no_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (ipi_set == '0 && ipi_clr == '0 && tmr_clr == '0 && !wr_err));
endmodule

// File: rtl/ipt_pending_vec.sv
module ipt_pending_vec
  import ipt_pkg::*;
#(
  parameter int N        = 4,
  parameter bit SET_WINS = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic nxt;
    assign nxt = pend_next(q_o[b], set_i[b], clr_i[b], SET_WINS);

    always_ff @(posedge clk) begin
      if (!rst_n) q_o[b] <= 1'b0;
      else        q_o[b] <= nxt;
    end

    // R2: a set that is not overridden lands on the next edge
    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[b] && (SET_WINS || !clr_i[b])) |=> q_o[b]);
    // R3: a clear that is not overridden lands on the next edge
    p_clr_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[b] && (!SET_WINS || !set_i[b])) |=> !q_o[b]);
    // R7: without a strobe the bit holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[b] && !clr_i[b]) |=> $stable(q_o[b]));
  end
endmodule

// File: rtl/ipi_timer_irq_unit.sv
module ipi_timer_irq_unit
  import ipt_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [1:0]        req_cpu,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic              tick,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   tmr_irq
);
  localparam int PAD = MAX_CPU - NCPU;

  logic [NCPU-1:0]    ipi_set, ipi_clr, tmr_clr, tmr_set;
  logic [NCPU-1:0]    ipi_pend, tmr_pend;
  logic [MAX_CPU-1:0] ipi_w, tmr_w;
  logic               wr_err, rd_en;

  ipt_bus_decode #(.NCPU(NCPU)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ipi_set   (ipi_set),
    .ipi_clr   (ipi_clr),
    .tmr_clr   (tmr_clr),
    .wr_err    (wr_err),
    .rd_en     (rd_en)
  );

  assign tmr_set = {NCPU{tick}};

  ipt_pending_vec #(.N(NCPU), .SET_WINS(1'b0)) u_ipi (
    .clk (clk), .rst_n (rst_n), .set_i (ipi_set), .clr_i (ipi_clr), .q_o (ipi_pend)
  );

  ipt_pending_vec #(.N(NCPU), .SET_WINS(1'b1)) u_tmr (
    .clk (clk), .rst_n (rst_n), .set_i (tmr_set), .clr_i (tmr_clr), .q_o (tmr_pend)
  );

  if (PAD > 0) begin : g_pad
    assign ipi_w = {{PAD{1'b0}}, ipi_pend};
    assign tmr_w = {{PAD{1'b0}}, tmr_pend};
  end else begin : g_nopad
    assign ipi_w = ipi_pend;
    assign tmr_w = tmr_pend;
  end

  always_comb begin
    rsp_rdata = '0;
    if (rd_en) begin
      unique case (reg_sel_e'(req_addr))
        RG_MISC:     rsp_rdata = misc_pack(ipi_w, tmr_w, req_cpu);
        RG_IPI_STAT: rsp_rdata[MAX_CPU-1:0] = ipi_w;
        RG_TMR_STAT: rsp_rdata[MAX_CPU-1:0] = tmr_w;
        default:     rsp_rdata = '0;
      endcase
    end
  end

  assign rsp_err = wr_err;
  assign ipi_irq = ipi_pend;
  assign tmr_irq = tmr_pend;

  // R8: after a tick every timer line is up
  p_tick_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (&tmr_irq));
  // R6: a rejected write changes no state
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err && !tick) |=> ($stable(ipi_irq) && $stable(tmr_irq)));
  // R13: a read changes no state
  p_read_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !tick) |=> ($stable(ipi_irq) && $stable(tmr_irq)));

  initial begin
    p_ncpu_range_r1: assert (NCPU >= 1 && NCPU <= MAX_CPU);
  end
endmodule

// File: tb/ipi_timer_irq_unit_tb.sv
`timescale 1ns/1ps
module ipi_timer_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, tick = 1'b0;
  logic [1:0]  req_addr = '0, req_cpu = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [3:0]  ipi_irq, tmr_irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] s_rd;
  logic        s_err;

  always #2.5 clk = ~clk;

  ipi_timer_irq_unit #(.NCPU(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .tick(tick),
    .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, sample combinational response, step past edge.
  task automatic op(input logic v, input logic wr, input logic [1:0] a,
                    input logic [31:0] d, input logic [1:0] cpu, input logic tk);
    @(negedge clk);
    req_valid = v; req_write = wr; req_addr = a; req_wdata = d; req_cpu = cpu; tick = tk;
    #1;
    s_rd = rsp_rdata; s_err = rsp_err;
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_write = 1'b0; tick = 1'b0;
  endtask

  task automatic set_ipi(input logic [3:0] s);
    op(1, 1, 2'd1, 32'hF, 0, 0);
    if (s != 0) op(1, 1, 2'd3, {28'd0, s}, 0, 0);
  endtask

  task automatic set_tmr(input logic [3:0] t);
    op(0, 0, 0, 0, 0, 1);
    if ((~t & 4'hF) != 0) op(1, 1, 2'd2, {28'd0, ~t & 4'hF}, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    check("R1 ipi after reset", {28'd0, ipi_irq}, 0);
    check("R1 tmr after reset", {28'd0, tmr_irq}, 0);
    op(1, 0, 2'd0, 0, 2'd2, 0);
    check("R13 misc read after reset", s_rd, 32'h2);

    // R2 R3 R7 R11 R6: full sweep of prior state x post x clear
    for (int s = 0; s < 16; s++) begin
      for (int rq = 0; rq < 16; rq++) begin
        for (int cl = 0; cl < 16; cl++) begin
          set_ipi(s[3:0]);
          check("R11 queue post", {28'd0, ipi_irq}, s);
          op(1, 1, 2'd0, (rq << 12) | (cl << 8), 0, 0);
          check("R6 misc error flag", {31'd0, s_err}, (rq == 0 && cl == 0) ? 1 : 0);
          check("R2/R3/R7 ipi after misc", {28'd0, ipi_irq}, (s | rq) & ~cl & 4'hF);
        end
      end
    end

    // R4 R10 R12: timer clears through both paths
    for (int c = 0; c < 16; c++) begin
      op(0, 0, 0, 0, 0, 1);
      check("R8 tick sets all", {28'd0, tmr_irq}, 32'hF);
      op(1, 1, 2'd0, c << 4, 0, 0);
      check("R6 misc tmr-only error", {31'd0, s_err}, (c == 0) ? 1 : 0);
      check("R4 timer clear via misc", {28'd0, tmr_irq}, ~c & 4'hF);
      op(0, 0, 0, 0, 0, 1);
      op(1, 1, 2'd2, c, 0, 0);
      check("R12 tmr stat zero error", {31'd0, s_err}, (c == 0) ? 1 : 0);
      check("R10 timer clear via stat", {28'd0, tmr_irq}, ~c & 4'hF);
      // R8: tick beats a clear of every bit in the same cycle
      set_tmr(c[3:0]);
      op(1, 1, 2'd0, 32'hF0, 0, 1);
      check("R8 tick wins over clear", {28'd0, tmr_irq}, 32'hF);
    end

    // R9 R10 R13: reads of every register for swept states
    for (int s = 0; s < 16; s++) begin
      for (int cpu = 0; cpu < 4; cpu++) begin
        logic [3:0] t;
        t = 4'(s * 5 + cpu);
        set_ipi(s[3:0]);
        set_tmr(t);
        op(1, 0, 2'd1, 0, cpu[1:0], 0);
        check("R9 ipi stat read", s_rd, s);
        op(1, 0, 2'd2, 0, cpu[1:0], 0);
        check("R10 tmr stat read", s_rd, {28'd0, t});
        op(1, 0, 2'd0, 0, cpu[1:0], 0);
        check("R13 misc read", s_rd, (s << 8) | (t << 4) | cpu);
        check("R13 read leaves ipi", {28'd0, ipi_irq}, s);
      end
      // R9 clear through status register, R12 zero vector
      for (int c = 0; c < 16; c++) begin
        set_ipi(s[3:0]);
        op(1, 1, 2'd1, c, 0, 0);
        check("R12 ipi stat zero error", {31'd0, s_err}, (c == 0) ? 1 : 0);
        check("R9 ipi stat clear", {28'd0, ipi_irq}, s & ~c & 4'hF);
      end
    end

    // R5: acknowledge bit alone; R12: empty queue write
    set_ipi(4'hA); set_tmr(4'h5);
    op(1, 1, 2'd0, 32'h1000_0000, 0, 0);
    check("R5 ack no error", {31'd0, s_err}, 0);
    check("R5 ack keeps ipi", {28'd0, ipi_irq}, 32'hA);
    check("R5 ack keeps tmr", {28'd0, tmr_irq}, 32'h5);
    op(1, 1, 2'd3, 32'h0, 0, 0);
    check("R12 queue zero error", {31'd0, s_err}, 1);
    check("R12 queue zero keeps ipi", {28'd0, ipi_irq}, 32'hA);
    op(1, 1, 2'd0, 32'h0, 0, 0);
    check("R6 empty misc error", {31'd0, s_err}, 1);
    check("R6 empty misc keeps tmr", {28'd0, tmr_irq}, 32'h5);

    // R1: reset in mid-run clears both vectors
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 ipi after re-reset", {28'd0, ipi_irq}, 0);
    check("R1 tmr after re-reset", {28'd0, tmr_irq}, 0);
    rst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule